// File: doc/BRIEF.md
# Word/Byte Switchable Static RAM Front End

This block is a clocked, synthesizable model of the control and data path at the pins of a static RAM that can be organized either as 16-bit words or as 8-bit bytes. It takes the usual RAM control pins: a pair of chip selects with opposite polarity, active-low write and output enables, active-low selects for the lower and upper byte lanes, and an active-low pin that puts the part into byte organization. It decodes these pins into writes to a small word-wide storage array with a write strobe per byte. It also produces the data it drives back, together with an enable for each of the 16 lanes. The bidirectional bus is split into an input vector, an output vector and an output-enable vector.

In word organization the byte selects choose which lanes take part in an access. In byte organization only the low eight lanes carry data. The top bus pin then becomes an extra low-order address bit that picks which half of the addressed word is accessed. All pins are sampled on the system clock. Writes land at that edge, and the drive and lane enables are registered, so the bus turns around one clock after the controlling pins change.

Top module: `sram_org_front`

## Requirements
- R1: While `csel_n` is 1 or `csel_hi` is 0, the part is in standby: after the next clock edge `dq_oe` is all zero, and no storage location changes, whatever the other pins do.
- R2: In word organization (`bmode_n` = 1) with both `lsel_n` and `usel_n` at 1, the part is in standby: after the next edge no lane is driven, and no write takes place.
- R3: In a word-organization read, `lsel_n` = 0 enables lanes 7..0 and `usel_n` = 0 enables lanes 15..8, so `dq_oe` is 16'h00FF, 16'hFF00 or 16'hFFFF. The enabled lanes carry the matching bytes of the addressed word.
- R4: A storage write takes place only in a cycle where `csel_n` = 0, `csel_hi` = 1, `wen_n` = 0 and at least one lane is selected. In byte organization a lane counts as selected by the byte-mode pin itself. A word write stores `dq_in[7:0]` into the low byte and `dq_in[15:8]` into the high byte of the word at `addr`.
- R5: While `wen_n` = 0, `oen_n` has no effect and no lane is driven. While `wen_n` = 1 and `oen_n` = 1, no lane is driven.
- R6: In byte organization (`bmode_n` = 0), `lsel_n` and `usel_n` have no effect. A read drives exactly lanes 7..0 (`dq_oe` = 16'h00FF), and lanes 15..8 are never driven.
- R7: In byte organization, `dq_in[15]` is the low-order address bit. A value of 0 reads or writes bits 7..0 of the word at `addr`, and a value of 1 reads or writes bits 15..8 of that word, always through lanes 7..0.
- R8: `dq_oe` and `dq_out` change only at a clock edge. They reflect the pins sampled at that edge, so a read presented between edges shows nothing on the outputs before the following edge.
- R9: Every lane whose `dq_oe` bit is 0 has its `dq_out` bit at 0.
- R10: A synchronous reset (`rst` = 1 at an edge) clears `dq_oe`, `dq_out` and every storage word to zero.
- R11: A word-organization write with only one byte select low leaves the other byte of the addressed word unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| csel_n | input | 1 | Active-low chip select |
| csel_hi | input | 1 | Active-high chip select |
| wen_n | input | 1 | Active-low write enable |
| oen_n | input | 1 | Active-low output enable |
| lsel_n | input | 1 | Active-low lower byte lane select (word organization) |
| usel_n | input | 1 | Active-low upper byte lane select (word organization) |
| bmode_n | input | 1 | Active-low byte organization select |
| addr | input | AW | Word address, AW = clog2(DEPTH) |
| dq_in | input | 16 | Bus value seen at the pins; bit 15 is the extra address bit in byte organization |
| dq_out | output | 16 | Registered read data, zero on undriven lanes |
| dq_oe | output | 16 | Registered per-lane output enable |

## Verification
The bench builds the block with DEPTH = 16, which gives a 4-bit address. With that setting the last word, address 15, can be written and read back next to address 0 in a short run, so both address limits are covered. The default of 64 words is kept for the lint build. A reference model in the bench holds the 16 words and tracks every partial write. This lets it detect a lost write, a write to the wrong byte, or a write that leaks through while the part is in standby.

// File: rtl/sof_pkg.sv
package sof_pkg;

    localparam int LANE_W = 8;
    localparam int LANE_N = 2;
    localparam int BUS_W  = LANE_W * LANE_N;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2,
        ACC_HIDE  = 2'd3
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e         kind;
        logic              byte_org;
        logic              half_sel;
        logic [LANE_N-1:0] lanes;
    } acc_t;

    function automatic logic [BUS_W-1:0] lane_mask(input logic [LANE_N-1:0] lanes);
        logic [BUS_W-1:0] m;
        m = '0;
        for (int i = 0; i < LANE_N; i++) begin
            m[i*LANE_W +: LANE_W] = {LANE_W{lanes[i]}};
        end
        return m;
    endfunction

endpackage

// File: rtl/sof_decode.sv
module sof_decode
    import sof_pkg::*;
(
    input  logic             csel_n,
    input  logic             csel_hi,
    input  logic             wen_n,
    input  logic             oen_n,
    input  logic             lsel_n,
    input  logic             usel_n,
    input  logic             bmode_n,
    input  logic             extra_abit,
    output acc_t             acc
);

    logic              chip_on;
    logic [LANE_N-1:0] word_lanes;
    logic              any_lane;

    always_comb begin
        chip_on    = !csel_n && csel_hi;
        word_lanes = {!usel_n, !lsel_n};
        any_lane   = !bmode_n || (word_lanes != '0);

        acc.byte_org = !bmode_n;
        acc.half_sel = !bmode_n && extra_abit;
        if (!bmode_n) begin
            acc.lanes = extra_abit ? LANE_N'(2) : LANE_N'(1);
        end else begin
            acc.lanes = word_lanes;
        end

        if (!chip_on || !any_lane) begin
            acc.kind = ACC_IDLE;
        end else if (!wen_n) begin
            acc.kind = ACC_WRITE;
        end else if (!oen_n) begin
            acc.kind = ACC_READ;
        end else begin
            acc.kind = ACC_HIDE;
        end
    end

endmodule

// File: rtl/sof_wsteer.sv
module sof_wsteer
    import sof_pkg::*;
(
    input  acc_t              acc,
    input  logic [BUS_W-1:0]  dq_in,
    output logic [LANE_N-1:0] wstrobe,
    output logic [BUS_W-1:0]  wdata
);

    always_comb begin
        wstrobe = '0;
        wdata   = dq_in;
        if (acc.kind == ACC_WRITE) begin
            if (acc.byte_org) begin
                wstrobe[acc.half_sel] = 1'b1;
                for (int i = 0; i < LANE_N; i++) begin
                    wdata[i*LANE_W +: LANE_W] = dq_in[LANE_W-1:0];
                end
            end else begin
                wstrobe = acc.lanes;
            end
        end
    end

endmodule

// File: rtl/sof_store.sv
module sof_store
    import sof_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [AW-1:0]     addr,
    input  logic [LANE_N-1:0] wstrobe,
    input  logic [BUS_W-1:0]  wdata,
    output logic [BUS_W-1:0]  rdata
);

    for (genvar g = 0; g < LANE_N; g++) begin : g_bank
        logic [LANE_W-1:0] bank [DEPTH];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int w = 0; w < DEPTH; w++) begin
                    bank[w] <= '0;
                end
            end else if (wstrobe[g]) begin
                bank[addr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        assign rdata[g*LANE_W +: LANE_W] = bank[addr];
    end

endmodule

// File: rtl/sof_drive.sv
module sof_drive
    import sof_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  acc_t             acc,
    input  logic [BUS_W-1:0] rdata,
    output logic [BUS_W-1:0] dq_out,
    output logic [BUS_W-1:0] dq_oe
);

    logic [BUS_W-1:0] oe_nxt;
    logic [BUS_W-1:0] out_nxt;

    always_comb begin
        oe_nxt  = '0;
        out_nxt = '0;
        if (acc.kind == ACC_READ) begin
            if (acc.byte_org) begin
                oe_nxt[LANE_W-1:0]  = '1;
                out_nxt[LANE_W-1:0] = rdata[LANE_W*int'(acc.half_sel) +: LANE_W];
            end else begin
                oe_nxt  = lane_mask(acc.lanes);
                out_nxt = rdata & oe_nxt;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dq_oe  <= '0;
            dq_out <= '0;
        end else begin
            dq_oe  <= oe_nxt;
            dq_out <= out_nxt;
        end
    end

endmodule

// File: rtl/sram_org_front.sv
module sram_org_front
    import sof_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             csel_n,
    input  logic             csel_hi,
    input  logic             wen_n,
    input  logic             oen_n,
    input  logic             lsel_n,
    input  logic             usel_n,
    input  logic             bmode_n,
    input  logic [AW-1:0]    addr,
    input  logic [BUS_W-1:0] dq_in,
    output logic [BUS_W-1:0] dq_out,
    output logic [BUS_W-1:0] dq_oe
);

    acc_t              acc;
    logic [LANE_N-1:0] wstrobe;
    logic [BUS_W-1:0]  wdata;
    logic [BUS_W-1:0]  rdata;

    sof_decode u_decode (
        .csel_n     (csel_n),
        .csel_hi    (csel_hi),
        .wen_n      (wen_n),
        .oen_n      (oen_n),
        .lsel_n     (lsel_n),
        .usel_n     (usel_n),
        .bmode_n    (bmode_n),
        .extra_abit (dq_in[BUS_W-1]),
        .acc        (acc)
    );

    sof_wsteer u_wsteer (
        .acc     (acc),
        .dq_in   (dq_in),
        .wstrobe (wstrobe),
        .wdata   (wdata)
    );

    sof_store #(.DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst     (rst),
        .addr    (addr),
        .wstrobe (wstrobe),
        .wdata   (wdata),
        .rdata   (rdata)
    );

    sof_drive u_drive (
        .clk    (clk),
        .rst    (rst),
        .acc    (acc),
        .rdata  (rdata),
        .dq_out (dq_out),
        .dq_oe  (dq_oe)
    );

endmodule

// File: rtl/sram_org_front_chk.sv
module sram_org_front_chk (
    input logic        clk,
    input logic        rst,
    input logic        csel_n,
    input logic        csel_hi,
    input logic        wen_n,
    input logic        oen_n,
    input logic        lsel_n,
    input logic        usel_n,
    input logic        bmode_n,
    input logic [15:0] dq_out,
    input logic [15:0] dq_oe
);

    a_r1_standby_quiet: assert property (@(posedge clk) disable iff (rst)
        (csel_n || !csel_hi) |=> (dq_oe == 16'h0000));

    a_r2_no_lane_quiet: assert property (@(posedge clk) disable iff (rst)
        (!csel_n && csel_hi && bmode_n && lsel_n && usel_n) |=> (dq_oe == 16'h0000));

    a_r3_low_lane_only: assert property (@(posedge clk) disable iff (rst)
        (!csel_n && csel_hi && bmode_n && wen_n && !oen_n && !lsel_n && usel_n)
        |=> (dq_oe == 16'h00FF));

    a_r5_write_no_drive: assert property (@(posedge clk) disable iff (rst)
        (!wen_n || oen_n) |=> (dq_oe == 16'h0000));

    a_r6_byte_upper_float: assert property (@(posedge clk) disable iff (rst)
        !bmode_n |=> (dq_oe[15:8] == 8'h00));

    a_r9_zero_undriven: assert property (@(posedge clk) disable iff (rst)
        ((dq_out & ~dq_oe) == 16'h0000));

    a_r8_hold_between: assert property (@(posedge clk) disable iff (rst)
        (csel_n && $past(csel_n) && !$past(rst)) |=> $stable(dq_oe));

endmodule

bind sram_org_front sram_org_front_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .csel_n  (csel_n),
    .csel_hi (csel_hi),
    .wen_n   (wen_n),
    .oen_n   (oen_n),
    .lsel_n  (lsel_n),
    .usel_n  (usel_n),
    .bmode_n (bmode_n),
    .dq_out  (dq_out),
    .dq_oe   (dq_oe)
);

// File: tb/sram_org_front_bench.sv
module sram_org_front_bench;

    localparam int DEPTH = 16;
    localparam int AW    = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          csel_n = 1'b1, csel_hi = 1'b0, wen_n = 1'b1, oen_n = 1'b1;
    logic          lsel_n = 1'b1, usel_n = 1'b1, bmode_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [15:0]   dq_in = '0;
    logic [15:0]   dq_out, dq_oe;

    int vectors = 0;
    int miscompares = 0;

    logic [15:0] model [DEPTH];
    logic [15:0] q_oe [$];
    logic [15:0] q_out [$];
    string       q_tag [$];

    always #10 clk = ~clk;

    sram_org_front #(.DEPTH(DEPTH)) u_sram_org_front (
        .clk(clk), .rst(rst), .csel_n(csel_n), .csel_hi(csel_hi),
        .wen_n(wen_n), .oen_n(oen_n), .lsel_n(lsel_n), .usel_n(usel_n),
        .bmode_n(bmode_n), .addr(addr), .dq_in(dq_in),
        .dq_out(dq_out), .dq_oe(dq_oe)
    );

    task automatic chk(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Driver: presents one cycle of pins and queues the expected registered result.
    task automatic apply(input logic cs_n, input logic cs_h, input logic we_n,
                         input logic oe_n, input logic lb_n, input logic ub_n,
                         input logic by_n, input logic [AW-1:0] a,
                         input logic [15:0] d, input string tag);
        logic        on, byt, sel;
        logic [1:0]  wl;
        logic [15:0] eoe, eout;
        on   = !cs_n && cs_h;
        byt  = !by_n;
        wl   = {!ub_n, !lb_n};
        sel  = on && (byt || wl != 2'b00);
        eoe  = '0;
        eout = '0;
        if (sel && we_n && !oe_n) begin
            if (byt) begin
                eoe  = 16'h00FF;
                eout = {8'h00, d[15] ? model[a][15:8] : model[a][7:0]};
            end else begin
                eoe  = {{8{wl[1]}}, {8{wl[0]}}};
                eout = model[a] & eoe;
            end
        end
        if (sel && !we_n) begin
            if (byt) begin
                if (d[15]) model[a][15:8] = d[7:0];
                else       model[a][7:0]  = d[7:0];
            end else begin
                if (wl[0]) model[a][7:0]  = d[7:0];
                if (wl[1]) model[a][15:8] = d[15:8];
            end
        end
        @(negedge clk);
        csel_n = cs_n; csel_hi = cs_h; wen_n = we_n; oen_n = oe_n;
        lsel_n = lb_n; usel_n = ub_n; bmode_n = by_n; addr = a; dq_in = d;
        @(posedge clk);
        #1;
        q_oe.push_back(eoe);
        q_out.push_back(eout);
        q_tag.push_back(tag);
    endtask

    // Word-organization read of both lanes
    task automatic wrd(input logic [AW-1:0] a, input string tag);
        apply(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, a, 16'h0000, tag);
    endtask

    // Monitor: compares registered outputs against queued expectations.
    always @(negedge clk) begin
        if (q_oe.size() > 0) begin
            logic [15:0] eo, ed;
            string       t;
            eo = q_oe.pop_front();
            ed = q_out.pop_front();
            t  = q_tag.pop_front();
            chk(t, "dq_oe", dq_oe, eo);
            chk(t, "dq_out", dq_out, ed);
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) model[i] = 16'h0000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R10: outputs clear out of reset, storage reads zero
        chk("R10", "dq_oe", dq_oe, 16'h0000);
        chk("R10", "dq_out", dq_out, 16'h0000);
        wrd(4'd5, "R10");

        // R4 word write, R3 full and partial lane reads, R9 zero on undriven lanes
        apply(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'd3, 16'h1234, "R4");
        wrd(4'd3, "R4");
        apply(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 4'd3, 16'h0000, "R3_R9");
        apply(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 4'd3, 16'h0000, "R3_R9");

        // R11 upper-only write keeps low byte; then lower-only write keeps high byte
        apply(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 4'd3, 16'hABCD, "R11");
        wrd(4'd3, "R11");
        apply(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'd3, 16'h5577, "R11");
        wrd(4'd3, "R11");

        // R1 standby blocks writes and drive, both chip select polarities
        apply(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd3, 16'hFFFF, "R1");
        apply(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd3, 16'hEEEE, "R1");
        apply(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 4'd3, 16'h0000, "R1");
        wrd(4'd3, "R1");

        // R2 no byte select in word organization
        apply(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 4'd3, 16'h9999, "R2");
        apply(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4'd3, 16'h0000, "R2");
        wrd(4'd3, "R2");

        // R5 write enable masks output enable; output enable high floats
        apply(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd9, 16'h0F0F, "R5");
        apply(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'd9, 16'h0000, "R5");
        wrd(4'd9, "R5");

        // R7 byte organization: extra address bit picks the half; R6 selects ignored
        apply(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 4'd7, 16'h805A, "R7");
        apply(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 4'd7, 16'h8000, "R7_R6");
        apply(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd7, 16'h0000, "R7_R6");
        apply(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd7, 16'h7FC3, "R7");
        wrd(4'd7, "R7");
        apply(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd7, 16'h0000, "R6");

        // Address limits
        apply(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'd15, 16'hC0DE, "R4");
        apply(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'd0, 16'h600D, "R4");
        wrd(4'd15, "R4");
        wrd(4'd0, "R4");

        // R8: a read presented between edges is not visible before the next edge
        apply(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 4'd0, 16'h0000, "R8");
        @(negedge clk);
        csel_n = 1'b0; csel_hi = 1'b1; wen_n = 1'b1; oen_n = 1'b0;
        lsel_n = 1'b0; usel_n = 1'b0; bmode_n = 1'b1; addr = 4'd15;
        #5;
        chk("R8", "dq_oe before edge", dq_oe, 16'h0000);
        @(posedge clk);
        #1;
        chk("R8", "dq_oe after edge", dq_oe, 16'hFFFF);
        chk("R8", "dq_out after edge", dq_out, model[15]);

        // R10: reset mid-run clears storage and outputs
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < DEPTH; i++) model[i] = 16'h0000;
        chk("R10", "dq_oe", dq_oe, 16'h0000);
        wrd(4'd15, "R10");

        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule